// File: doc/BRIEF.md
# Codec Control Write Master (two-wire serial)

This block lets software program the control registers of an audio converter over a two-wire serial bus in the I2C style. Software places a packed codec word into a data port: a 7-bit register index and a 9-bit value. It then writes the control register with the device address and a go bit. The block sends a START condition and the address byte with the write direction. Next it sends the index together with the top value bit, then the low eight value bits, and closes with a STOP. After every byte it samples the acknowledge slot.

Completion shows as the go bit clearing by itself. A missing acknowledge sets a sticky fault bit, ends the frame with an immediate STOP and also clears the go bit. Any retrying is left to software. A single-byte mode sends only the first data byte. With the closing flag clear, the block ends the frame without a STOP and keeps the clock low. The next go then begins with a repeated START and takes its word from the second data port.

Both bus lines are open-drain. The block drives an output enable that pulls the line low and reads back a sampled copy of SDA. Each bit period has four phases, and each phase lasts `clk_div + 1` clock cycles.

Top module: `codec_i2c_wr`

## Requirements
- R1: After reset every register reads as zero and both line enables are 0 (lines released). The control register (select 0) holds the address in bits 7:1, the direction bit in bit 0, go in bit 8, fault in bit 9, close-with-STOP in bit 10 and single-byte mode in bit 11. All other bits read 0.
- R2: Data port 0 (select 1) and data port 1 (select 2) each store bits 31:16 of a write. Bits 31:25 are the register index and bits 24:16 are the value. Bits 15:0 read back as 0.
- R3: A full frame is START, then {address, 0}, then {index, value[8]}, then value[7:0], then STOP, with an acknowledge slot after each byte. The stored direction bit is never transmitted; the bus always sees a write.
- R4: The go bit reads 1 from the cycle after an accepted write with bit 8 set, and clears by itself when the frame ends.
- R5: A missing acknowledge on any byte stops transmission after that byte, issues STOP, clears go and sets the fault bit. A frame in which every byte is acknowledged leaves fault at 0.
- R6: The fault bit stays 1 until software writes the control register again while the block is idle. That write clears it.
- R7: With bit 11 set, only the address byte and the first data byte are sent before STOP.
- R8: With bit 10 clear, the frame ends after its last acknowledge with no STOP and SCL held low. The next go issues a repeated START and sends the word from data port 1. A go on a free bus sends the word from data port 0.
- R9: SDA changes only while SCL is low, except at START and STOP. One bit period lasts 4*(clk_div+1) cycles.
- R10: A control register write made while go reads 1 has no effect on any control field, and it does not start a second frame.
- R11: An enable of 1 pulls its line low, and an enable of 0 releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | DIV_W | Cycles per bit phase minus one |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 data port 0, 2 data port 1 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the selected register |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level |

## Verification
Read data appears one cycle after the select is presented. The bench therefore presents the select on a falling edge and samples on the next falling edge. A write takes effect at the rising edge that samples it, so go reads 1 on the following read. The frame itself takes tens of bit periods, so the bench polls the go bit rather than predicting its exact clear cycle. The serial side is judged by a bus model that records bytes, STOP and the spacing of SCL rises in whole clock cycles. Bus results are checked only after go has cleared, once the last line change has landed.

// File: rtl/codec_i2c_pkg.sv
`timescale 1ns/1ps
package codec_i2c_pkg;
  localparam int REG_W   = 32;
  localparam int WORD_W  = 16;
  localparam int WORD_LO = 16;
  localparam int DEV_W   = 7;

  localparam int CTRL_RW     = 0;
  localparam int CTRL_DEV_LO = 1;
  localparam int CTRL_START  = 8;
  localparam int CTRL_ABORT  = 9;
  localparam int CTRL_LAST   = 10;
  localparam int CTRL_SINGLE = 11;

  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_DATA0 = 2'd1;
  localparam logic [1:0] SEL_DATA1 = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_ACK,
    ST_STOP,
    ST_HOLD
  } eng_state_t;
endpackage

// File: rtl/codec_i2c_regs.sv
`timescale 1ns/1ps
module codec_i2c_regs import codec_i2c_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              eng_done,
  input  logic              eng_nack,
  output logic              go,
  output logic              busy,
  output logic              abort,
  output logic              last,
  output logic              single,
  output logic [DEV_W-1:0]  dev,
  output logic [WORD_W-1:0] word0,
  output logic [WORD_W-1:0] word1
);
  logic rw_q;
  logic ctrl_wr;
  logic unused_bits;

  assign ctrl_wr     = we && (addr == SEL_CTRL);
  assign unused_bits = ^{wdata[REG_W-1:CTRL_SINGLE+1], wdata[CTRL_ABORT], wdata[WORD_LO-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      go     <= 1'b0;
      busy   <= 1'b0;
      abort  <= 1'b0;
      last   <= 1'b0;
      single <= 1'b0;
      dev    <= '0;
      rw_q   <= 1'b0;
      word0  <= '0;
      word1  <= '0;
    end else begin
      go <= 1'b0;
      if (we && addr == SEL_DATA0) word0 <= wdata[REG_W-1:WORD_LO];
      if (we && addr == SEL_DATA1) word1 <= wdata[REG_W-1:WORD_LO];
      if (eng_done) begin
        busy  <= 1'b0;
        abort <= eng_nack;
      end else if (ctrl_wr && !busy) begin
        rw_q   <= wdata[CTRL_RW];
        dev    <= wdata[CTRL_DEV_LO +: DEV_W];
        last   <= wdata[CTRL_LAST];
        single <= wdata[CTRL_SINGLE];
        abort  <= 1'b0;
        if (wdata[CTRL_START]) begin
          busy <= 1'b1;
          go   <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      case (addr)
        SEL_CTRL: begin
          rdata[CTRL_RW]                <= rw_q;
          rdata[CTRL_DEV_LO +: DEV_W]   <= dev;
          rdata[CTRL_START]             <= busy;
          rdata[CTRL_ABORT]             <= abort;
          rdata[CTRL_LAST]              <= last;
          rdata[CTRL_SINGLE]            <= single;
        end
        SEL_DATA0: rdata[REG_W-1:WORD_LO] <= word0;
        SEL_DATA1: rdata[REG_W-1:WORD_LO] <= word1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/codec_i2c_tick.sv
`timescale 1ns/1ps
module codec_i2c_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = en && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !en) cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/codec_i2c_engine.sv
`timescale 1ns/1ps
module codec_i2c_engine import codec_i2c_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              tick,
  input  logic              sda_s,
  input  logic [DEV_W-1:0]  dev,
  input  logic              last,
  input  logic              single,
  input  logic [WORD_W-1:0] word0,
  input  logic [WORD_W-1:0] word1,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              active,
  output logic              done,
  output logic              nack,
  output eng_state_t        st_o
);
  eng_state_t        st;
  logic [1:0]        ph;
  logic [1:0]        byten;
  logic [1:0]        nbytes;
  logic [2:0]        bitn;
  logic [7:0]        sh;
  logic [WORD_W-1:0] wq;
  logic              last_q;
  logic              miss_q;
  logic              ackbad;

  assign active = (st == ST_START) || (st == ST_BIT) || (st == ST_ACK) || (st == ST_STOP);
  assign st_o   = st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ph     <= 2'd0;
      byten  <= 2'd0;
      nbytes <= 2'd3;
      bitn   <= 3'd0;
      sh     <= '0;
      wq     <= '0;
      last_q <= 1'b0;
      miss_q <= 1'b0;
      ackbad <= 1'b0;
      done   <= 1'b0;
      nack   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        st     <= ST_START;
        ph     <= 2'd0;
        sh     <= {dev, 1'b0};
        byten  <= 2'd0;
        bitn   <= 3'd0;
        nbytes <= single ? 2'd2 : 2'd3;
        last_q <= last;
        wq     <= (st == ST_HOLD) ? word1 : word0;
        miss_q <= 1'b0;
        ackbad <= 1'b0;
      end else if (tick) begin
        ph <= ph + 2'd1;
        if (st == ST_ACK && ph == 2'd2) ackbad <= sda_s;
        if (ph == 2'd3) begin
          case (st)
            ST_START: begin
              st   <= ST_BIT;
              bitn <= 3'd0;
            end
            ST_BIT: begin
              if (bitn == 3'd7) begin
                st <= ST_ACK;
              end else begin
                bitn <= bitn + 3'd1;
                sh   <= {sh[6:0], 1'b0};
              end
            end
            ST_ACK: begin
              if (ackbad) begin
                miss_q <= 1'b1;
                st     <= ST_STOP;
              end else if (byten == nbytes - 2'd1) begin
                if (last_q) begin
                  st <= ST_STOP;
                end else begin
                  st   <= ST_HOLD;
                  done <= 1'b1;
                  nack <= 1'b0;
                end
              end else begin
                byten <= byten + 2'd1;
                bitn  <= 3'd0;
                st    <= ST_BIT;
                sh    <= (byten == 2'd0) ? wq[WORD_W-1 -: 8] : wq[7:0];
              end
            end
            ST_STOP: begin
              st   <= ST_IDLE;
              done <= 1'b1;
              nack <= miss_q;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_START: begin
          scl_oe <= (ph == 2'd0) || (ph == 2'd3);
          sda_oe <= (ph == 2'd2) || (ph == 2'd3);
        end
        ST_BIT: begin
          scl_oe <= (ph == 2'd0) || (ph == 2'd3);
          sda_oe <= ~sh[7];
        end
        ST_ACK: begin
          scl_oe <= (ph == 2'd0) || (ph == 2'd3);
          sda_oe <= 1'b0;
        end
        ST_STOP: begin
          scl_oe <= (ph == 2'd0);
          sda_oe <= (ph == 2'd0) || (ph == 2'd1);
        end
        ST_HOLD: begin
          scl_oe <= 1'b1;
          sda_oe <= 1'b0;
        end
        default: begin
          scl_oe <= 1'b0;
          sda_oe <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/codec_i2c_wr.sv
`timescale 1ns/1ps
module codec_i2c_wr import codec_i2c_pkg::*; #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  logic              go;
  logic              busy;
  logic              abort_flag;
  logic              ctl_last;
  logic              ctl_single;
  logic [DEV_W-1:0]  ctrl_dev;
  logic [WORD_W-1:0] word0;
  logic [WORD_W-1:0] word1;
  logic              eng_done;
  logic              eng_nack;
  logic              eng_active;
  logic              tick;
  logic              sda_m;
  logic              sda_s;
  eng_state_t        eng_st;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_m <= 1'b1;
      sda_s <= 1'b1;
    end else begin
      sda_m <= sda_in;
      sda_s <= sda_m;
    end
  end

  codec_i2c_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .eng_done(eng_done), .eng_nack(eng_nack), .go(go),
    .busy(busy), .abort(abort_flag), .last(ctl_last), .single(ctl_single),
    .dev(ctrl_dev), .word0(word0), .word1(word1)
  );

  codec_i2c_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .en(eng_active), .div(clk_div), .tick(tick)
  );

  codec_i2c_engine u_eng (
    .clk(clk), .rst(rst), .go(go), .tick(tick), .sda_s(sda_s), .dev(ctrl_dev),
    .last(ctl_last), .single(ctl_single), .word0(word0), .word1(word1),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .active(eng_active), .done(eng_done),
    .nack(eng_nack), .st_o(eng_st)
  );
endmodule

// File: rtl/codec_i2c_chk.sv
`timescale 1ns/1ps
module codec_i2c_chk import codec_i2c_pkg::*; (
  input logic             clk,
  input logic             rst,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic             busy,
  input logic             abort_flag,
  input logic             eng_done,
  input logic             eng_nack,
  input logic [DEV_W-1:0] ctrl_dev,
  input eng_state_t       eng_st
);
  // R9
  sda_move_chk: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (eng_st == ST_START || eng_st == ST_STOP));

  // R10
  busy_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == SEL_CTRL && busy) |=> $stable(ctrl_dev));

  // R4
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(eng_done));

  // R5
  abort_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(abort_flag) |-> $past(eng_done && eng_nack));

  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_st == ST_IDLE && $past(eng_st == ST_IDLE)) |-> (!scl_oe && !sda_oe));

  // R8
  hold_low_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_st == ST_HOLD && $past(eng_st == ST_HOLD)) |-> (scl_oe && !sda_oe));
endmodule

bind codec_i2c_wr codec_i2c_chk u_chk (
  .clk(clk), .rst(rst), .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_we(reg_we),
  .reg_addr(reg_addr), .busy(busy), .abort_flag(abort_flag),
  .eng_done(eng_done), .eng_nack(eng_nack), .ctrl_dev(ctrl_dev), .eng_st(eng_st)
);

// File: tb/test_codec_i2c_wr.sv
`timescale 1ns/1ps
module test_codec_i2c_wr;
  localparam int DIV_W = 8;
  localparam int CLK_DIV = 2;

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] d0;
    logic [31:0] d1;
    logic [1:0]  nack;
    logic [7:0]  b0;
    logic [7:0]  b1;
    logic [7:0]  b2;
    logic [1:0]  nb;
    logic        ab;
    logic        stp;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{32'h534, 32'h2A040000, 32'h0,        2'd3, 8'h34, 8'h2A, 8'h04, 2'd3, 1'b0, 1'b1},
    '{32'h535, 32'hFFFF0000, 32'h0,        2'd3, 8'h34, 8'hFF, 8'hFF, 2'd3, 1'b0, 1'b1},
    '{32'h534, 32'h2A040000, 32'h0,        2'd0, 8'h34, 8'h00, 8'h00, 2'd1, 1'b1, 1'b1},
    '{32'h534, 32'h2A040000, 32'h0,        2'd2, 8'h34, 8'h2A, 8'h04, 2'd3, 1'b1, 1'b1},
    '{32'hD34, 32'h1DCF0000, 32'h0,        2'd3, 8'h34, 8'h1D, 8'h00, 2'd2, 1'b0, 1'b1},
    '{32'h134, 32'h1AC30000, 32'h5A5A0000, 2'd3, 8'h34, 8'h1A, 8'hC3, 2'd3, 1'b0, 1'b0},
    '{32'h534, 32'h77770000, 32'h21000000, 2'd3, 8'h34, 8'h21, 8'h00, 2'd3, 1'b0, 1'b1}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] clk_div = DIV_W'(CLK_DIV);
  logic             reg_we = 1'b0;
  logic [1:0]       reg_addr = 2'd0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             scl_oe;
  logic             sda_oe;
  logic             slv_ack = 1'b0;
  wire              scl_line = ~scl_oe;
  wire              sda_line = ~(sda_oe | slv_ack);

  int errs = 0;
  int checks = 0;
  int cyc = 0;

  // bus model state
  int        nack_at = 3;
  int        bitcnt = 0;
  int        nbytes = 0;
  logic      in_ack = 1'b0;
  logic      stop_seen = 1'b0;
  logic [7:0] shreg = '0;
  logic [7:0] cap [0:3];
  int        t_rise1 = 0;
  int        t_rise2 = 0;

  codec_i2c_wr #(.DIV_W(DIV_W)) i_codec_i2c_wr (
    .clk(clk), .rst(rst), .clk_div(clk_div), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(sda_line)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  always @(negedge sda_line) if (scl_line) begin
    bitcnt = 0; nbytes = 0; in_ack = 1'b0; stop_seen = 1'b0;
  end
  always @(posedge sda_line) if (scl_line) stop_seen = 1'b1;
  always @(posedge scl_line) if (!in_ack) begin
    if (nbytes == 0 && bitcnt == 1) t_rise1 = cyc;
    if (nbytes == 0 && bitcnt == 2) t_rise2 = cyc;
    shreg = {shreg[6:0], sda_line};
    bitcnt = bitcnt + 1;
  end
  always @(negedge scl_line) begin
    if (bitcnt == 8 && !in_ack) begin
      if (nbytes < 4) cap[nbytes] = shreg;
      slv_ack = (nbytes != nack_at);
      in_ack = 1'b1;
      nbytes = nbytes + 1;
      bitcnt = 0;
    end else if (in_ack) begin
      slv_ack = 1'b0;
      in_ack = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_done(output logic [31:0] v);
    v = 32'h100;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd0, v);
      if (!v[8]) break;
    end
    chk("R4 go self-clears", 32'(v[8]), 32'd0);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  function automatic string vreq(int i);
    case (i)
      0, 1:    return "R3";
      2, 3:    return "R5";
      4:       return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog R4 actual=running expected=finished");
    report();
  end

  initial begin
    logic [31:0] v;
    logic [7:0] eb [0:2];
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 R11 reset state
    rd(2'd0, v); chk("R1 ctrl after reset", v, 32'h0);
    rd(2'd1, v); chk("R1 data0 after reset", v, 32'h0);
    chk("R11 scl released", 32'(scl_oe), 32'd0);
    chk("R11 sda released", 32'(sda_oe), 32'd0);

    // table walk
    for (int i = 0; i < 7; i++) begin
      nack_at = int'(VEC[i].nack);
      wr(2'd1, VEC[i].d0);
      wr(2'd2, VEC[i].d1);
      wr(2'd0, VEC[i].ctrl);
      wait_done(v);
      eb[0] = VEC[i].b0; eb[1] = VEC[i].b1; eb[2] = VEC[i].b2;
      chk({vreq(i), " fault bit"}, 32'(v[9]), 32'(VEC[i].ab));
      chk({vreq(i), " byte count"}, 32'(nbytes), 32'(VEC[i].nb));
      for (int k = 0; k < int'(VEC[i].nb); k++)
        chk({vreq(i), " byte"}, 32'(cap[k]), 32'(eb[k]));
      chk({vreq(i), " stop seen"}, 32'(stop_seen), 32'(VEC[i].stp));
      if (!VEC[i].stp) chk("R11 scl held low", 32'(scl_line), 32'd0);
      if (i == 0) chk("R9 bit period", 32'(t_rise2 - t_rise1), 32'(4 * (CLK_DIV + 1)));
    end

    // R6 fault stays until the next control write
    nack_at = 1;
    wr(2'd1, 32'h2A040000);
    wr(2'd0, 32'h534);
    wait_done(v);
    chk("R5 fault after data nack", 32'(v[9]), 32'd1);
    chk("R5 stop after nack", 32'(stop_seen), 32'd1);
    chk("R5 bytes before nack", 32'(nbytes), 32'd2);
    repeat (50) @(posedge clk);
    rd(2'd0, v); chk("R6 fault sticky", 32'(v[9]), 32'd1);
    wr(2'd0, 32'h034);
    rd(2'd0, v); chk("R6 fault cleared by write", v, 32'h034);
    nack_at = 3;

    // R10 control write during a frame is ignored
    wr(2'd1, 32'h2A040000);
    wr(2'd0, 32'h534);
    repeat (40) @(posedge clk);
    rd(2'd0, v); chk("R4 go reads 1 mid-frame", 32'(v[8]), 32'd1);
    wr(2'd0, 32'h5A0);
    wait_done(v);
    chk("R10 address unchanged", 32'(v[7:0]), 32'h34);
    chk("R10 first byte", 32'(cap[0]), 32'h34);
    repeat (200) @(posedge clk);
    rd(2'd0, v); chk("R10 no second frame", 32'(v[8]), 32'd0);
    chk("R10 byte count kept", 32'(nbytes), 32'd3);

    // R2 data port storage
    wr(2'd2, 32'hFFFFFFFF);
    rd(2'd2, v); chk("R2 data1 low bits", v, 32'hFFFF0000);
    wr(2'd1, 32'h12345678);
    rd(2'd1, v); chk("R2 data0 low bits", v, 32'h12340000);

    report();
  end
endmodule